// File: doc/BRIEF.md
# Programmable-Polynomial Block Check Unit

This block keeps a running cyclic block check over serial character streams for two directions at once, receive and transmit. Both directions use one generator polynomial held in a register that software loads at run time, so the same hardware serves any 16-bit check code. Framing logic presents one bit per cycle with a valid strobe and a direction select. Software can preset either accumulator, clear it, and read its value. The polynomial register drives both accumulators.

Alongside the block check, the unit tracks character boundaries from a programmable character length of 1 to 16 bits. It produces even or odd parity for each transmitted character. On receive, it treats the bit that follows each character as that character's parity bit, checks it, and keeps that bit out of the block check. At the end of a received block an end-of-block strobe samples the receive accumulator. A nonzero remainder sets the block-check error flag.

Top module: `blkchk_unit`

## Requirements
- R1: The polynomial register resets to 16'h8005 and holds the x^15..x^0 taps, with the x^16 term implied. A software write with `sw_sel` = 2 loads it, and its value then applies to both directions.
- R2: Each accepted check bit updates only its own direction's accumulator (`bit_dir` 0 = receive, 1 = transmit). The accumulator shifts left one place with a zero into bit 0, and the polynomial is XORed in when the old bit 15 XOR the input bit is 1. Without a bit, write or clear, an accumulator holds its value.
- R3: A software write with `sw_sel` = 0 (receive) or 1 (transmit) presets that accumulator to `sw_wdata` on the next cycle. A check bit for the same direction in that cycle is dropped from the check.
- R4: `clr_rx` zeroes the receive accumulator, both receive error flags and the receive character position. `clr_tx` zeroes the transmit accumulator, the transmit character position and `tx_par`. A clear wins over a same-cycle write or bit.
- R5: When `eob_rx` is high, `bcc_err` is loaded with 1 if the receive accumulator is nonzero after this cycle's update, which includes a bit accepted in the same cycle. Otherwise `bcc_err` holds its value.
- R6: On receive, after `char_len_m1`+1 data bits the next receive bit is the parity bit. It does not enter the block check. If it differs from the expected parity, `vrc_err` is set and stays set until `clr_rx`.
- R7: Expected parity is the XOR of the character's data bits for even parity (`par_odd` = 0), and its inverse for odd parity (`par_odd` = 1).
- R8: On transmit, the cycle after the last data bit of a character, `tx_par` holds that character's parity bit and `tx_par_vld` pulses high for one cycle.
- R9: Character lengths from 1 (`char_len_m1` = 0) to 16 (`char_len_m1` = 15) are supported in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Serial bit strobe |
| bit_dir | input | 1 | 0 = receive, 1 = transmit |
| bit_val | input | 1 | Serial bit value |
| char_len_m1 | input | 4 | Character length minus one |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 2 | 0 receive acc, 1 transmit acc, 2 polynomial |
| sw_wdata | input | 16 | Write data |
| clr_rx | input | 1 | Receive clear strobe |
| clr_tx | input | 1 | Transmit clear strobe |
| eob_rx | input | 1 | Receive end-of-block strobe |
| rx_bcc | output | 16 | Receive accumulator |
| tx_bcc | output | 16 | Transmit accumulator |
| poly | output | 16 | Polynomial register |
| bcc_err | output | 1 | Receive block-check error |
| vrc_err | output | 1 | Receive parity error, sticky |
| tx_par | output | 1 | Parity of last transmitted character |
| tx_par_vld | output | 1 | One-cycle pulse when `tx_par` updates |

## Verification
The end-of-block sample and the last check bit can fall in the same cycle. So can a software preset or a clear and an incoming bit for the same direction. The bench provokes the first case by raising `eob_rx` together with the final bit of the received check characters, and expects `bcc_err` to reflect the remainder that includes that bit. It provokes the second case by driving a write or clear alongside a bit. It then expects the preset or zero value, and no trace of the bit. A behavioural model steps in parallel and judges every cycle, and directed checks also name the expected constants.

// File: rtl/blkchk_pkg.sv
package blkchk_pkg;
   typedef enum logic [1:0] {
      SEL_RX   = 2'd0,
      SEL_TX   = 2'd1,
      SEL_POLY = 2'd2,
      SEL_NONE = 2'd3
   } sw_sel_e;
endpackage

// File: rtl/blkchk_acc.sv
module blkchk_acc #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         shift,
   input  logic         bit_in,
   input  logic [W-1:0] taps,
   output logic [W-1:0] acc,
   output logic [W-1:0] acc_nxt
);
   logic         fb;
   logic [W-1:0] stepped;

   assign fb = acc[W-1] ^ bit_in;

   // one serial step, unrolled per bit position
   for (genvar i = 0; i < W; i++) begin : g_step
      if (i == 0) begin : g_lsb
         assign stepped[i] = fb & taps[i];
      end else begin : g_upper
         assign stepped[i] = acc[i-1] ^ (fb & taps[i]);
      end
   end

   always_comb begin
      if (clr)        acc_nxt = '0;
      else if (ld)    acc_nxt = ld_val;
      else if (shift) acc_nxt = stepped;
      else            acc_nxt = acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc_nxt;
   end
endmodule

// File: rtl/blkchk_par.sv
module blkchk_par #(
   parameter int LEN_W = 4,
   parameter bit IS_RX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic [LEN_W-1:0] len_m1,
   input  logic             odd,
   output logic             data_en,
   output logic             evt,
   output logic             par_val
);
   localparam int CNT_W = LEN_W + 1;

   logic [CNT_W-1:0] cnt;
   logic             acc_par;
   logic [CNT_W-1:0] last_idx;

   assign last_idx = {1'b0, len_m1};

   if (IS_RX) begin : g_rx
      logic slot;
      // the bit after the last data bit is the parity bit
      assign slot    = (cnt == last_idx + CNT_W'(1));
      assign data_en = bit_vld & ~slot;
      assign evt     = bit_vld & slot;
      assign par_val = acc_par ^ odd;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            cnt     <= '0;
            acc_par <= 1'b0;
         end else if (bit_vld) begin
            if (slot) begin
               cnt     <= '0;
               acc_par <= 1'b0;
            end else begin
               cnt     <= cnt + CNT_W'(1);
               acc_par <= acc_par ^ bit_in;
            end
         end
      end
   end else begin : g_tx
      logic last;
      assign last    = (cnt == last_idx);
      assign data_en = bit_vld;
      assign evt     = bit_vld & last;
      assign par_val = acc_par ^ bit_in ^ odd;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            cnt     <= '0;
            acc_par <= 1'b0;
         end else if (bit_vld) begin
            if (last) begin
               cnt     <= '0;
               acc_par <= 1'b0;
            end else begin
               cnt     <= cnt + CNT_W'(1);
               acc_par <= acc_par ^ bit_in;
            end
         end
      end
   end
endmodule

// File: rtl/blkchk_unit.sv
module blkchk_unit #(
   parameter int          W        = 16,
   parameter int          CHAR_MAX = 16,
   parameter logic [15:0] POLY_RST = 16'h8005,
   localparam int         LEN_W    = $clog2(CHAR_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_dir,
   input  logic             bit_val,
   input  logic [LEN_W-1:0] char_len_m1,
   input  logic             par_odd,
   input  logic             sw_wr,
   input  logic [1:0]       sw_sel,
   input  logic [W-1:0]     sw_wdata,
   input  logic             clr_rx,
   input  logic             clr_tx,
   input  logic             eob_rx,
   output logic [W-1:0]     rx_bcc,
   output logic [W-1:0]     tx_bcc,
   output logic [W-1:0]     poly,
   output logic             bcc_err,
   output logic             vrc_err,
   output logic             tx_par,
   output logic             tx_par_vld
);
   import blkchk_pkg::*;

   if (W < 2 || W > 16) begin : g_bad_w
      $error("blkchk_unit: W must be 2..16");
   end
   if (CHAR_MAX < 2 || (1 << LEN_W) != CHAR_MAX) begin : g_bad_len
      $error("blkchk_unit: CHAR_MAX must be a power of two >= 2");
   end

   logic rx_bit, tx_bit;
   logic rx_data, tx_data;
   logic rx_slot, tx_last;
   logic rx_exp, tx_pv;
   logic rx_ld, tx_ld;
   logic [W-1:0] rx_nxt, tx_nxt;

   assign rx_bit = bit_vld & ~bit_dir;
   assign tx_bit = bit_vld &  bit_dir;
   assign rx_ld  = sw_wr & (sw_sel == SEL_RX);
   assign tx_ld  = sw_wr & (sw_sel == SEL_TX);

   blkchk_par #(.LEN_W(LEN_W), .IS_RX(1'b1)) u_rx_par (
      .clk(clk), .rst_n(rst_n), .clr(clr_rx), .bit_vld(rx_bit),
      .bit_in(bit_val), .len_m1(char_len_m1), .odd(par_odd),
      .data_en(rx_data), .evt(rx_slot), .par_val(rx_exp)
   );

   blkchk_par #(.LEN_W(LEN_W), .IS_RX(1'b0)) u_tx_par (
      .clk(clk), .rst_n(rst_n), .clr(clr_tx), .bit_vld(tx_bit),
      .bit_in(bit_val), .len_m1(char_len_m1), .odd(par_odd),
      .data_en(tx_data), .evt(tx_last), .par_val(tx_pv)
   );

   blkchk_acc #(.W(W)) u_rx_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_rx), .ld(rx_ld), .ld_val(sw_wdata),
      .shift(rx_data), .bit_in(bit_val), .taps(poly),
      .acc(rx_bcc), .acc_nxt(rx_nxt)
   );

   blkchk_acc #(.W(W)) u_tx_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_tx), .ld(tx_ld), .ld_val(sw_wdata),
      .shift(tx_data), .bit_in(bit_val), .taps(poly),
      .acc(tx_bcc), .acc_nxt(tx_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         poly <= POLY_RST[W-1:0];
      end else if (sw_wr && sw_sel == SEL_POLY) begin
         poly <= sw_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_rx) begin
         bcc_err <= 1'b0;
         vrc_err <= 1'b0;
      end else begin
         if (eob_rx) bcc_err <= |rx_nxt;
         if (rx_slot && (bit_val != rx_exp)) vrc_err <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_tx) begin
         tx_par     <= 1'b0;
         tx_par_vld <= 1'b0;
      end else begin
         tx_par_vld <= tx_last;
         if (tx_last) tx_par <= tx_pv;
      end
   end

   // tx_nxt is only observed through tx_bcc; keep it referenced
   logic tx_nxt_unused;
   assign tx_nxt_unused = ^tx_nxt;
endmodule

// File: rtl/blkchk_chk.sv
module blkchk_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bit_vld,
   input logic         bit_dir,
   input logic         sw_wr,
   input logic [1:0]   sw_sel,
   input logic [W-1:0] sw_wdata,
   input logic         clr_rx,
   input logic         clr_tx,
   input logic         eob_rx,
   input logic [W-1:0] rx_bcc,
   input logic [W-1:0] tx_bcc,
   input logic [W-1:0] poly,
   input logic         bcc_err,
   input logic         vrc_err,
   input logic         tx_par_vld
);
   p_poly_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_wr && sw_sel == 2'd2) |=> $stable(poly));

   p_tx_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_vld && bit_dir) && !(sw_wr && sw_sel == 2'd1) && !clr_tx |=> $stable(tx_bcc));

   p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_vld && !bit_dir) && !(sw_wr && sw_sel == 2'd0) && !clr_rx |=> $stable(rx_bcc));

   p_tx_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr && sw_sel == 2'd1 && !clr_tx |=> tx_bcc == $past(sw_wdata));

   p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rx |=> rx_bcc == '0 && !bcc_err && !vrc_err);

   p_bcc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !eob_rx && !clr_rx |=> $stable(bcc_err));

   p_vrc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vrc_err && !clr_rx |=> vrc_err);

   p_par_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_par_vld |-> $past(bit_vld && bit_dir && !clr_tx));
endmodule

bind blkchk_unit blkchk_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dir(bit_dir),
   .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
   .clr_rx(clr_rx), .clr_tx(clr_tx), .eob_rx(eob_rx),
   .rx_bcc(rx_bcc), .tx_bcc(tx_bcc), .poly(poly),
   .bcc_err(bcc_err), .vrc_err(vrc_err), .tx_par_vld(tx_par_vld)
);

// File: tb/blkchk_unit_tb.sv
module blkchk_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_vld = 0, bit_dir = 0, bit_val = 0;
   logic [3:0]  char_len_m1 = 4'd7;
   logic        par_odd = 0;
   logic        sw_wr = 0;
   logic [1:0]  sw_sel = 2'd3;
   logic [15:0] sw_wdata = 0;
   logic        clr_rx = 0, clr_tx = 0, eob_rx = 0;
   logic [15:0] rx_bcc, tx_bcc, poly;
   logic        bcc_err, vrc_err, tx_par, tx_par_vld;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   blkchk_unit dut_i (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dir(bit_dir),
      .bit_val(bit_val), .char_len_m1(char_len_m1), .par_odd(par_odd),
      .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
      .clr_rx(clr_rx), .clr_tx(clr_tx), .eob_rx(eob_rx),
      .rx_bcc(rx_bcc), .tx_bcc(tx_bcc), .poly(poly),
      .bcc_err(bcc_err), .vrc_err(vrc_err), .tx_par(tx_par), .tx_par_vld(tx_par_vld)
   );

   // ---------------- behavioural reference model ----------------
   int m_rx, m_tx, m_poly;
   int m_bcc, m_vrc, m_txpar, m_txvld;
   int m_rxcnt, m_rxpar, m_txcnt, m_txpar_run;

   function automatic int crc_step(int acc, int b, int p);
      int top;
      top = (acc >> 15) & 1;
      acc = (acc * 2) % 65536;
      if ((top ^ b) != 0) acc = acc ^ p;
      return acc;
   endfunction

   always @(posedge clk) begin
      int len;
      int n_rx, n_tx;
      len = int'(char_len_m1) + 1;
      if (!rst_n) begin
         m_rx = 0; m_tx = 0; m_poly = 16'h8005;
         m_bcc = 0; m_vrc = 0; m_txpar = 0; m_txvld = 0;
         m_rxcnt = 0; m_rxpar = 0; m_txcnt = 0; m_txpar_run = 0;
      end else begin
         n_rx = m_rx;
         n_tx = m_tx;
         // receive side
         if (clr_rx) begin
            n_rx = 0; m_bcc = 0; m_vrc = 0; m_rxcnt = 0; m_rxpar = 0;
         end else begin
            if (sw_wr && sw_sel == 2'd0) n_rx = sw_wdata;
            if (bit_vld && !bit_dir) begin
               if (m_rxcnt == len) begin
                  if (int'(bit_val) != (m_rxpar ^ int'(par_odd))) m_vrc = 1;
                  m_rxcnt = 0; m_rxpar = 0;
               end else begin
                  if (!(sw_wr && sw_sel == 2'd0)) n_rx = crc_step(m_rx, bit_val, m_poly);
                  m_rxpar = m_rxpar ^ int'(bit_val);
                  m_rxcnt++;
               end
            end
            if (eob_rx) m_bcc = (n_rx != 0) ? 1 : 0;
         end
         // transmit side
         m_txvld = 0;
         if (clr_tx) begin
            n_tx = 0; m_txcnt = 0; m_txpar_run = 0; m_txpar = 0;
         end else begin
            if (sw_wr && sw_sel == 2'd1) n_tx = sw_wdata;
            else if (bit_vld && bit_dir) n_tx = crc_step(m_tx, bit_val, m_poly);
            if (bit_vld && bit_dir) begin
               if (m_txcnt == len - 1) begin
                  m_txpar = m_txpar_run ^ int'(bit_val) ^ int'(par_odd);
                  m_txvld = 1; m_txcnt = 0; m_txpar_run = 0;
               end else begin
                  m_txpar_run = m_txpar_run ^ int'(bit_val);
                  m_txcnt++;
               end
            end
         end
         if (sw_wr && sw_sel == 2'd2) m_poly = sw_wdata;
         m_rx = n_rx;
         m_tx = n_tx;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 poly", poly, m_poly);
         chk("R2/R3/R4 rx_bcc", rx_bcc, m_rx);
         chk("R2/R3/R4 tx_bcc", tx_bcc, m_tx);
         chk("R5 bcc_err", bcc_err, m_bcc);
         chk("R6 vrc_err", vrc_err, m_vrc);
         chk("R7 tx_par", tx_par, m_txpar);
         chk("R8 tx_par_vld", tx_par_vld, m_txvld);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      bit_vld = 0; sw_wr = 0; sw_sel = 2'd3; clr_rx = 0; clr_tx = 0; eob_rx = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic send_bit(logic dir, logic b, logic eob);
      bit_vld = 1; bit_dir = dir; bit_val = b; eob_rx = eob;
      step();
   endtask

   task automatic sw_write(logic [1:0] sel, logic [15:0] d);
      sw_wr = 1; sw_sel = sel; sw_wdata = d;
      step();
   endtask

   // data bits MSB first, then (rx only) a parity bit
   task automatic send_char(logic dir, logic [15:0] d, int len, bit bad_par, bit eob_last);
      int ones = 0;
      for (int i = len - 1; i >= 0; i--) begin
         ones += d[i];
         send_bit(dir, d[i], eob_last && !(dir == 0) && i == 0);
      end
      if (dir == 0) begin
         logic p;
         p = logic'((ones % 2) ^ int'(par_odd) ^ int'(bad_par));
         send_bit(0, p, eob_last);
      end
   endtask

   initial begin
      #(20 * 150000);
      $display("FAIL watchdog expired");
      failures++;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] crc;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R1, R4)
      chk("R1 reset poly", poly, 16'h8005);
      chk("R4 reset rx_bcc", rx_bcc, 0);
      chk("R4 reset tx_bcc", tx_bcc, 0);

      // R1 program polynomial, R2 transmit stream
      sw_write(2'd2, 16'h1021);
      chk("R1 poly loaded", poly, 16'h1021);
      char_len_m1 = 4'd7; par_odd = 0;
      send_char(1, 16'h31, 8, 0, 0);
      send_char(1, 16'h32, 8, 0, 0);
      send_char(1, 16'h33, 8, 0, 0);
      crc = tx_bcc;
      chk("R2 tx check nonzero", int'(crc != 0), 1);
      // R8 parity of 0x33 (four ones, even parity) = 0
      chk("R8 tx_par even 0x33", tx_par, 0);

      // R5/R6 good receive block; eob together with last bit (parity of last check char)
      send_char(0, 16'h31, 8, 0, 0);
      send_char(0, 16'h32, 8, 0, 0);
      send_char(0, 16'h33, 8, 0, 0);
      send_char(0, {8'h00, crc[15:8]}, 8, 0, 0);
      send_char(0, {8'h00, crc[7:0]}, 8, 0, 1);
      chk("R5 good block bcc_err", bcc_err, 0);
      chk("R6 good parity vrc_err", vrc_err, 0);
      chk("R6 rx remainder zero", rx_bcc, 0);

      // R5 eob in same cycle as last data bit of check char
      clr_rx = 1; step();
      send_char(0, 16'h31, 8, 0, 0);
      send_char(0, 16'h32, 8, 0, 0);
      send_char(0, 16'h33, 8, 0, 0);
      send_char(0, {8'h00, crc[15:8]}, 8, 0, 0);
      for (int i = 7; i >= 0; i--) send_bit(0, crc[i], i == 0);
      chk("R5 same-cycle eob good", bcc_err, 0);
      send_bit(0, 1'b0, 0);

      // R5/R6 corrupted block, bad parity
      clr_rx = 1; step();
      send_char(0, 16'h30, 8, 1, 0);
      send_char(0, {8'h00, crc[15:8]}, 8, 0, 0);
      send_char(0, {8'h00, crc[7:0]}, 8, 0, 1);
      chk("R5 bad block bcc_err", bcc_err, 1);
      chk("R6 bad parity vrc_err", vrc_err, 1);
      repeat (3) step();
      chk("R6 vrc_err sticky", vrc_err, 1);

      // R3 write wins over same-cycle bit
      sw_wr = 1; sw_sel = 2'd1; sw_wdata = 16'hA5A5; bit_vld = 1; bit_dir = 1; bit_val = 1;
      step();
      chk("R3 preset beats bit", tx_bcc, 16'hA5A5);
      // R2 rx bit leaves tx untouched
      send_bit(0, 1, 0);
      chk("R2 tx unaffected by rx bit", tx_bcc, 16'hA5A5);
      // R4 clear wins over write
      clr_tx = 1; sw_wr = 1; sw_sel = 2'd1; sw_wdata = 16'h1234;
      step();
      chk("R4 clear beats write", tx_bcc, 0);
      clr_rx = 1; step();
      chk("R4 clear errors", int'({bcc_err, vrc_err}), 0);

      // R9 length 16 with odd parity, length 1
      par_odd = 1; char_len_m1 = 4'd15;
      send_char(1, 16'hFFFE, 16, 0, 0);
      chk("R7 odd parity 15 ones", tx_par, 0);
      char_len_m1 = 4'd0;
      send_char(1, 16'h0001, 1, 0, 0);
      chk("R9 len1 odd parity of 1", tx_par, 0);
      send_char(0, 16'h0000, 1, 0, 0);
      send_char(0, 16'h0001, 1, 1, 0);
      chk("R9 len1 rx bad parity", vrc_err, 1);

      // random mix, judged by the model each cycle
      clr_rx = 1; clr_tx = 1; step();
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         bit_vld = (r < 70);
         bit_dir = $urandom % 2;
         bit_val = $urandom % 2;
         eob_rx = ($urandom % 20) == 0;
         if (r >= 96) begin
            sw_wr = 1; sw_sel = 2'($urandom % 4); sw_wdata = 16'($urandom);
         end
         clr_rx = ($urandom % 150) == 0;
         clr_tx = ($urandom % 150) == 0;
         if (n % 500 == 0) begin
            char_len_m1 = 4'($urandom % 16);
            par_odd = $urandom % 2;
            clr_rx = 1; clr_tx = 1;
         end
         step();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule